// File: doc/BRIEF.md
# Indexed Receive Buffer Descriptor Controller

This block owns the descriptor of one receive subaddress of a command/response serial-bus remote terminal running in indexed buffer mode. A host loads the descriptor (control, index count, data pointer, broadcast pointer) through a small register-write port. The bus side announces each accepted message with a start strobe carrying the message info word, its time tag and its data word count, then hands over the data words one at a time. The block turns that into a stream of RAM writes at ascending addresses: info word first, then time tag, then the data words in order.

After the last data word of a message, and only in index mode, the block counts the index down. The pointer moves past the stored message while more indexed messages remain. The message that drains the index does not move it, so every later message lands on the same slot. That same message raises a single-cycle interrupt unless the interrupt is masked. Once the index is zero, nothing moves any more and no further interrupts appear. Host writes that arrive while a message is being stored are parked and applied once it has finished, so a message always sees one consistent descriptor.

Top module: `idx_rxbuf_ctrl`

## Requirements
- R1: A synchronous active-low reset clears every descriptor word to zero, holds `ram_we` and `idx_irq` low, and so leaves the block in non-index mode with a pointer of 0x0000.
- R2: A message stored from pointer P writes the info word at P, the time tag at P+1 and data word k (k = 1..n) at P+1+k, one write per cycle for info and tag and one per accepted data word, in that order.
- R3: In index mode (control bit 15 = 1) with index I > 1, a completed n-word message sets the index to I-1 and moves the pointer forward by n+2.
- R4: A word-count field value of 0 on `msg_wcnt` means 32 data words; 1 to 31 mean themselves.
- R5: When a completed message takes the index from 1 to 0 in index mode with control bit 14 = 0, `idx_irq` is high for exactly one cycle, the cycle right after that message's last RAM write, and the pointer is left unchanged.
- R6: Control bit 14 = 1 masks the interrupt: the index still counts down to zero, but `idx_irq` stays low.
- R7: With the index at zero, messages leave the index at zero and the pointer unchanged, so each one overwrites the same slot, and none raises `idx_irq`.
- R8: With control bit 15 = 0, messages are stored from the current pointer and neither the index nor the pointer changes.
- R9: Host write select encoding is 0 = control, 1 = index, 2 = data pointer, 3 = broadcast pointer. A write in an idle cycle takes effect for the next message. A write that arrives during a message, or in the same cycle as its start strobe, is held and takes effect only after that message completes.
- R10: Writes to the broadcast pointer have no effect on any RAM address, RAM data or interrupt.
- R11: A start strobe while a message is in progress, and a data strobe outside the data phase of a message, are ignored: they cause no RAM write and do not change the message in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host descriptor write strobe |
| host_wr_sel | input | 2 | Descriptor word select (0 control, 1 index, 2 pointer, 3 broadcast) |
| host_wr_data | input | DW | Host write data |
| msg_start | input | 1 | Start of an accepted message for this subaddress |
| msg_wcnt | input | $clog2(MAXW) | Data word count of the message, 0 means MAXW |
| msg_info | input | DW | Message info word |
| msg_ttag | input | DW | Message time tag |
| dat_vld | input | 1 | Data word strobe |
| dat_word | input | DW | Data word |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | DW | RAM write address |
| ram_wdata | output | DW | RAM write data |
| idx_irq | output | 1 | Index-reached-zero interrupt pulse |

## Verification
The bench walks the index down from two to zero and keeps sending messages after it is exhausted. A design that still moves the pointer on the draining message, or that wraps the index below zero, would scatter later messages across fresh addresses and fire extra interrupts. It sends a count-field value of zero and expects 32 data words; a design that took the field literally would end the message after the time tag. It also parks a pointer write in the start cycle of a message and checks that the message itself still uses the old pointer while the next one uses the new pointer. Finally, it injects a stray start strobe and early data strobes during a message, which a careless sequencer would turn into extra or shifted RAM writes.

// File: rtl/rxb_pkg.sv
// Package: shared encodings of the indexed receive buffer controller.
// Assumes a 2-bit host word select and a 16-bit-or-wider control word.
package rxb_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_INDEX = 2'd1,
        SEL_PTR   = 2'd2,
        SEL_BCAST = 2'd3
    } desc_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INFO = 2'd1,
        ST_TTAG = 2'd2,
        ST_DATA = 2'd3
    } seq_state_e;

    localparam int CTRL_IDX_MODE_BIT = 15;
    localparam int CTRL_IRQ_MASK_BIT = 14;

endpackage

// File: rtl/rxb_hold_slot.sv
// Module: one held-write slot for a descriptor word.
// Passes a host write straight through when the descriptor is free, or parks
// it while a message is in progress and replays it on the first free cycle.
// Assumes 'hold' stays high from the start strobe to the last write.
module rxb_hold_slot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         hit,
    input  logic [W-1:0] din,
    output logic         load,
    output logic [W-1:0] val
);

    logic         pend_q;
    logic [W-1:0] pdat_q;

    // Park a write that arrives while the descriptor is locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            pdat_q <= '0;
        end else if (hold && hit) begin
            pend_q <= 1'b1;
            pdat_q <= din;
        end else if (!hold) begin
            pend_q <= 1'b0;
        end
    end

    // A fresh write wins over a parked one when both are due.
    assign load = !hold && (hit || pend_q);
    assign val  = hit ? din : pdat_q;

endmodule

// File: rtl/rxb_desc_regs.sv
// Module: descriptor word storage and the per-message index/pointer update.
// Control keeps only its mode and mask bits; broadcast writes are discarded,
// because broadcast messages are handled elsewhere. Host loads and message
// updates never coincide: loads need 'hold' low, updates happen while high.
module rxb_desc_regs
    import rxb_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          hold,
    input  logic          upd_en,
    input  logic [DW-1:0] upd_adv,
    output logic          idx_mode,
    output logic [DW-1:0] idx_cnt,
    output logic [DW-1:0] ptr_a,
    output logic          zero_hit
);

    localparam int NSLOT = 3;

    logic [NSLOT-1:0] hit;
    logic [NSLOT-1:0] load;
    logic [1:0]       ctrl_val;
    logic [DW-1:0]    idx_val;
    logic [DW-1:0]    ptr_val;
    logic             mode_q, mask_q;
    logic [DW-1:0]    idx_q, ptr_q;
    logic             step, last;

    // Decode the select into one hit per stored word.
    genvar g;
    generate
        for (g = 0; g < NSLOT; g++) begin : g_hit
            assign hit[g] = wr_en && (wr_sel == 2'(g));
        end
    endgenerate

    rxb_hold_slot #(.W(2)) u_slot_ctrl (
        .clk(clk), .rst_n(rst_n), .hold(hold), .hit(hit[SEL_CTRL]),
        .din({wr_data[CTRL_IDX_MODE_BIT], wr_data[CTRL_IRQ_MASK_BIT]}),
        .load(load[SEL_CTRL]), .val(ctrl_val)
    );

    rxb_hold_slot #(.W(DW)) u_slot_idx (
        .clk(clk), .rst_n(rst_n), .hold(hold), .hit(hit[SEL_INDEX]),
        .din(wr_data), .load(load[SEL_INDEX]), .val(idx_val)
    );

    rxb_hold_slot #(.W(DW)) u_slot_ptr (
        .clk(clk), .rst_n(rst_n), .hold(hold), .hit(hit[SEL_PTR]),
        .din(wr_data), .load(load[SEL_PTR]), .val(ptr_val)
    );

    // An indexed message steps the descriptor; the draining one leaves the pointer.
    assign step     = upd_en && mode_q && (idx_q != '0);
    assign last     = (idx_q == DW'(1));
    assign zero_hit = step && last && !mask_q;

    // Descriptor registers: host loads between messages, updates at message end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            mask_q <= 1'b0;
            idx_q  <= '0;
            ptr_q  <= '0;
        end else begin
            if (load[SEL_CTRL]) begin
                mode_q <= ctrl_val[1];
                mask_q <= ctrl_val[0];
            end
            if (load[SEL_INDEX])  idx_q <= idx_val;
            else if (step)        idx_q <= idx_q - DW'(1);
            if (load[SEL_PTR])    ptr_q <= ptr_val;
            else if (step && !last) ptr_q <= ptr_q + upd_adv;
        end
    end

    assign idx_mode = mode_q;
    assign idx_cnt  = idx_q;
    assign ptr_a    = ptr_q;

endmodule

// File: rtl/rxb_msg_seq.sv
// Module: message write sequencer.
// Emits info word, time tag and data words as RAM writes at ascending
// addresses from the base pointer, which must not change during a message.
// A count field of zero stands for MAXW words.
module rxb_msg_seq
    import rxb_pkg::*;
#(
    parameter int DW   = 16,
    parameter int MAXW = 32,
    localparam int NW  = $clog2(MAXW),
    localparam int CW  = $clog2(MAXW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          msg_start,
    input  logic [NW-1:0] msg_wcnt,
    input  logic [DW-1:0] msg_info,
    input  logic [DW-1:0] msg_ttag,
    input  logic          dat_vld,
    input  logic [DW-1:0] dat_word,
    input  logic [DW-1:0] base_ptr,
    output logic          ram_we,
    output logic [DW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] adv
);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] wr_q;
    logic [DW-1:0] info_q, ttag_q;
    logic          last_word;

    assign last_word = (wr_q + CW'(1)) == cnt_q;
    assign done      = (state_q == ST_DATA) && dat_vld && last_word;
    assign busy      = (state_q != ST_IDLE);
    assign adv       = DW'(cnt_q) + DW'(2);

    // Walk idle -> info -> time tag -> data, counting accepted data words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            wr_q    <= '0;
            info_q  <= '0;
            ttag_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (msg_start) begin
                    cnt_q   <= (msg_wcnt == '0) ? CW'(MAXW) : CW'(msg_wcnt);
                    info_q  <= msg_info;
                    ttag_q  <= msg_ttag;
                    wr_q    <= '0;
                    state_q <= ST_INFO;
                end
                ST_INFO: state_q <= ST_TTAG;
                ST_TTAG: state_q <= ST_DATA;
                ST_DATA: if (dat_vld) begin
                    wr_q <= wr_q + CW'(1);
                    if (last_word) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the RAM write for the current phase of the message.
    always_comb begin
        ram_we    = 1'b0;
        ram_addr  = base_ptr;
        ram_wdata = '0;
        unique case (state_q)
            ST_INFO: begin
                ram_we    = 1'b1;
                ram_wdata = info_q;
            end
            ST_TTAG: begin
                ram_we    = 1'b1;
                ram_addr  = base_ptr + DW'(1);
                ram_wdata = ttag_q;
            end
            ST_DATA: begin
                ram_we    = dat_vld;
                ram_addr  = base_ptr + DW'(2) + DW'(wr_q);
                ram_wdata = dat_word;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/idx_rxbuf_ctrl.sv
// Module: indexed receive buffer descriptor controller (top).
// Ties the descriptor storage to the message sequencer and registers the
// index-zero interrupt, so it pulses the cycle after the message's last write.
// Assumes the bus side raises msg_start only for messages to this subaddress.
module idx_rxbuf_ctrl #(
    parameter int DW   = 16,
    parameter int MAXW = 32,
    localparam int NW  = $clog2(MAXW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr_en,
    input  logic [1:0]    host_wr_sel,
    input  logic [DW-1:0] host_wr_data,
    input  logic          msg_start,
    input  logic [NW-1:0] msg_wcnt,
    input  logic [DW-1:0] msg_info,
    input  logic [DW-1:0] msg_ttag,
    input  logic          dat_vld,
    input  logic [DW-1:0] dat_word,
    output logic          ram_we,
    output logic [DW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          idx_irq
);

    logic          busy, done, zero_hit, idx_mode, irq_q;
    logic [DW-1:0] adv, idx_cnt, ptr_a;

    rxb_desc_regs #(.DW(DW)) u_desc (
        .clk(clk), .rst_n(rst_n),
        .wr_en(host_wr_en), .wr_sel(host_wr_sel), .wr_data(host_wr_data),
        .hold(busy || msg_start), .upd_en(done), .upd_adv(adv),
        .idx_mode(idx_mode), .idx_cnt(idx_cnt), .ptr_a(ptr_a),
        .zero_hit(zero_hit)
    );

    rxb_msg_seq #(.DW(DW), .MAXW(MAXW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .msg_start(msg_start), .msg_wcnt(msg_wcnt),
        .msg_info(msg_info), .msg_ttag(msg_ttag),
        .dat_vld(dat_vld), .dat_word(dat_word), .base_ptr(ptr_a),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .busy(busy), .done(done), .adv(adv)
    );

    // Register the interrupt so it follows the draining message's last write.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= zero_hit;
    end

    assign idx_irq = irq_q;

endmodule

// File: rtl/rxb_chk.sv
// Module: protocol checker for idx_rxbuf_ctrl, attached with bind.
// Observes the ports plus the descriptor state and the busy flag.
module rxb_chk #(
    parameter int DW   = 16,
    parameter int MAXW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          ram_we,
    input logic [DW-1:0] ram_addr,
    input logic          idx_irq,
    input logic          idx_mode,
    input logic [DW-1:0] idx_cnt,
    input logic [DW-1:0] ptr_a
);

    // R5: the interrupt lasts a single cycle.
    assert_irq_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idx_irq |=> !idx_irq);

    // R5: the interrupt follows a RAM write and the message has ended.
    assert_irq_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idx_irq |-> ($past(ram_we) && !busy && $past(idx_mode)));

    // R7: an exhausted index and its frozen pointer survive a message.
    assert_exhausted_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && idx_cnt == '0) |=> (idx_cnt == '0 && $stable(ptr_a)));

    // R2: every RAM write stays inside the current message slot.
    assert_write_in_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (busy && (DW'(ram_addr - ptr_a) <= DW'(MAXW + 1))));

    // R9: the descriptor pointer cannot move while a message is stored.
    assert_ptr_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ptr_a));

endmodule

bind idx_rxbuf_ctrl rxb_chk #(.DW(DW), .MAXW(MAXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ram_we(ram_we),
    .ram_addr(ram_addr), .idx_irq(idx_irq), .idx_mode(idx_mode),
    .idx_cnt(idx_cnt), .ptr_a(ptr_a)
);

// File: tb/tb_idx_rxbuf_ctrl.sv
module tb_idx_rxbuf_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 16;
    localparam int MAXW = 32;
    localparam int NW   = $clog2(MAXW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr_en = 1'b0;
    logic [1:0]    host_wr_sel = '0;
    logic [DW-1:0] host_wr_data = '0;
    logic          msg_start = 1'b0;
    logic [NW-1:0] msg_wcnt = '0;
    logic [DW-1:0] msg_info = '0;
    logic [DW-1:0] msg_ttag = '0;
    logic          dat_vld = 1'b0;
    logic [DW-1:0] dat_word = '0;
    logic          ram_we;
    logic [DW-1:0] ram_addr, ram_wdata;
    logic          idx_irq;

    idx_rxbuf_ctrl #(.DW(DW), .MAXW(MAXW)) dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel),
        .host_wr_data(host_wr_data),
        .msg_start(msg_start), .msg_wcnt(msg_wcnt),
        .msg_info(msg_info), .msg_ttag(msg_ttag),
        .dat_vld(dat_vld), .dat_word(dat_word),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .idx_irq(idx_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [DW-1:0] addr;
        logic [DW-1:0] data;
        bit            last;
        bit            irq;
        string         req;
    } item_t;

    item_t sb[$];
    int    n_chk = 0;
    int    n_err = 0;
    bit    irq_due = 0;
    bit    irq_exp = 0;
    string irq_req = "";
    bit    done_flag = 0;

    // reference descriptor model
    logic          m_mode = 0, m_mask = 0;
    logic [DW-1:0] m_idx = '0, m_ptr = '0;

    task automatic apply_model_write(input logic [1:0] sel, input logic [DW-1:0] v);
        case (sel)
            2'd0: begin m_mode = v[15]; m_mask = v[14]; end
            2'd1: m_idx = v;
            2'd2: m_ptr = v;
            default: ;
        endcase
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [DW-1:0] v);
        @(posedge clk); #1;
        host_wr_en = 1'b1; host_wr_sel = sel; host_wr_data = v;
        @(posedge clk); #1;
        host_wr_en = 1'b0;
        apply_model_write(sel, v);
    endtask

    // Driver: queue the expected writes, update the model, drive the message.
    task automatic send_msg(input int n, input logic [DW-1:0] info, input int gap,
                            input bit mid_wr, input logic [1:0] msel,
                            input logic [DW-1:0] mval, input bit stray,
                            input string req);
        int            cnt;
        logic [DW-1:0] base;
        item_t         it;
        bit            fire;
        cnt  = (n == 0) ? MAXW : n;
        base = m_ptr;
        fire = m_mode && (m_idx == DW'(1)) && !m_mask;
        it = '{base, info, 0, 0, req};
        sb.push_back(it);
        it = '{base + DW'(1), info ^ 16'h5A5A, 0, 0, req};
        sb.push_back(it);
        for (int k = 1; k <= cnt; k++) begin
            it = '{base + DW'(1) + DW'(k), info + DW'(k * 3), (k == cnt), fire, req};
            sb.push_back(it);
        end
        if (m_mode && m_idx != '0) begin
            if (m_idx != DW'(1)) m_ptr = m_ptr + DW'(cnt + 2);
            m_idx = m_idx - DW'(1);
        end
        if (mid_wr) apply_model_write(msel, mval);

        @(posedge clk); #1;
        msg_start = 1'b1; msg_wcnt = NW'(n); msg_info = info; msg_ttag = info ^ 16'h5A5A;
        if (mid_wr) begin
            host_wr_en = 1'b1; host_wr_sel = msel; host_wr_data = mval;
        end
        @(posedge clk); #1;
        host_wr_en = 1'b0;
        msg_start  = stray;
        msg_info   = 16'hDEAD;
        msg_wcnt   = NW'(1);
        dat_vld    = stray;
        dat_word   = 16'hBEEF;
        @(posedge clk); #1;
        msg_start = 1'b0;
        @(posedge clk); #1;
        dat_vld = 1'b0;
        for (int k = 1; k <= cnt; k++) begin
            dat_vld = 1'b1; dat_word = info + DW'(k * 3);
            @(posedge clk); #1;
            for (int j = 0; j < gap; j++) begin
                dat_vld = 1'b0; dat_word = 16'hFFFF;
                @(posedge clk); #1;
            end
        end
        dat_vld = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    // Monitor: compare RAM writes and the interrupt against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (irq_due) begin
                n_chk++;
                if (idx_irq !== irq_exp) begin
                    n_err++;
                    $display("FAIL %s R5 irq after last write: actual=%b expected=%b", irq_req, idx_irq, irq_exp);
                end
                irq_due = 0;
            end else if (idx_irq) begin
                n_chk++; n_err++;
                $display("FAIL R5 unexpected irq: actual=1 expected=0");
            end
            if (ram_we) begin
                n_chk++;
                if (sb.size() == 0) begin
                    n_err++;
                    $display("FAIL R11 extra RAM write: actual addr=%h data=%h expected none", ram_addr, ram_wdata);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    if (ram_addr !== it.addr || ram_wdata !== it.data) begin
                        n_err++;
                        $display("FAIL %s R2 RAM write: actual=%h/%h expected=%h/%h",
                                 it.req, ram_addr, ram_wdata, it.addr, it.data);
                    end
                    if (it.last) begin
                        irq_due = 1; irq_exp = it.irq; irq_req = it.req;
                    end
                end
            end
        end
    end

    task automatic finish_run;
        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (ram_we !== 1'b0) begin n_err++; $display("FAIL R1 ram_we in reset: actual=%b expected=0", ram_we); end
        n_chk++;
        if (idx_irq !== 1'b0) begin n_err++; $display("FAIL R1 irq in reset: actual=%b expected=0", idx_irq); end
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (ram_we !== 1'b0 || idx_irq !== 1'b0) begin
            n_err++; $display("FAIL R1 idle after reset: actual=%b%b expected=00", ram_we, idx_irq);
        end

        // R1/R8: zero descriptor, non-index mode, pointer stays at 0
        send_msg(3, 16'h1100, 0, 0, 2'd0, '0, 0, "R1");
        send_msg(2, 16'h2200, 1, 0, 2'd0, '0, 0, "R8");

        // R10: broadcast pointer is ignored
        host_write(2'd3, 16'h1234);
        host_write(2'd2, 16'h0500);
        host_write(2'd1, 16'h0002);
        host_write(2'd0, 16'h8000);
        // R3: index 2 -> 1, pointer 0x0500 -> 0x0505
        send_msg(3, 16'h3300, 0, 0, 2'd0, '0, 0, "R3");
        // R5: index 1 -> 0, interrupt, pointer stays 0x0505
        send_msg(4, 16'h4400, 1, 0, 2'd0, '0, 0, "R5");
        // R7: exhausted, same slot, no interrupt
        send_msg(1, 16'h5500, 0, 0, 2'd0, '0, 0, "R7");
        // R4: count field 0 means 32 words
        send_msg(0, 16'h6600, 0, 0, 2'd0, '0, 0, "R4");

        // R6: masked interrupt, index still counts
        host_write(2'd0, 16'hC000);
        host_write(2'd1, 16'h0001);
        send_msg(2, 16'h7700, 0, 0, 2'd0, '0, 0, "R6");
        host_write(2'd1, 16'h0002);
        send_msg(2, 16'h7800, 0, 0, 2'd0, '0, 0, "R6");

        // R9/R11: write in start cycle is held; stray strobes ignored
        host_write(2'd0, 16'h8000);
        send_msg(5, 16'h8800, 0, 1, 2'd2, 16'h0600, 1, "R9");
        send_msg(2, 16'h9900, 1, 0, 2'd0, '0, 0, "R9");
        // R10: broadcast write between messages changes nothing
        host_write(2'd3, 16'h0700);
        send_msg(1, 16'hAA00, 0, 0, 2'd0, '0, 1, "R10");

        repeat (4) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (sb.size() != 0) begin
            n_err++; $display("FAIL R2 missing writes: actual=%0d pending expected=0", sb.size());
        end
        finish_run();
    end

endmodule